// File: doc/BRIEF.md
# Six-Channel Compare Timer

A bus-mapped timer with six upward counters. Channels 1 to 5 hold 32-bit counters. Channel 6 holds a 64-bit counter, and its upper words sit in an extension slot. Each channel has four parts: a control word with enable, a self-clearing counter-reset strobe and a two-bit mode field; a clock-setting word that goes out to an external prescaler; the counter, which software can only read; and a compare value. The counter steps only when its tick input from the prescaler is high.

A compare hit in oneshot, repeat or keep-going mode raises that channel's bit in a shared status register. A shared enable register masks the status bits. Their AND, ORed across channels, drives one registered level interrupt. Software clears status by writing ones to an acknowledge address.

The bus is plain and synchronous. Writes take effect at the clock edge where the write enable is high. Read data is registered: it shows the addressed register one cycle after the address is presented.

Top module: `multi_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq_o` is low and `clk_cfg_o` is zero.
- R2: A channel's counter increases by exactly one on each clock edge where the channel is enabled (control bit 0) and its `tick_en` bit is high. A disabled channel, or an edge without its tick, leaves the counter unchanged.
- R3: In repeat mode (control bits [5:4] = 1), the tick that would bring the counter to the compare value instead returns the counter to zero. That tick sets the channel's status bit (status bit n-1 for channel n, at 0x04), and the channel keeps counting.
- R4: In oneshot mode (bits [5:4] = 0), the counter stops at the compare value. Control bit 0 reads back 0 and the status bit is set.
- R5: In keep-going mode (bits [5:4] = 2), reaching the compare value sets the status bit and the counter continues upward.
- R6: In free-run mode (bits [5:4] = 3), the counter never sets its status bit.
- R7: Writing control with bit 1 set forces the counter to zero at that edge, and bit 1 always reads back 0. Written together with bit 0, counting restarts from zero. A control write never advances the counter in the same cycle.
- R8: `irq_o` is high in the cycle after any status bit and its enable bit (register 0x00, bit n-1) are both set. It is low in the cycle after no such pair exists, so writing 0 to 0x00 masks every channel.
- R9: Writing ones to 0x08 clears the matching status bits, and 0x08 reads as zero. When a compare hit and an acknowledge of the same channel fall in one cycle, the status bit stays set.
- R10: Channel 6 counts and compares over 64 bits, and its upper compare word sits at 0x74. Reading the counter low word at 0x68 captures the upper counter word, which is then readable at 0x70.
- R11: Channel n has control at 0x10*n, clock setting at 0x10*n+4, counter at 0x10*n+8 and compare at 0x10*n+0xC. Read data appears one cycle after the address. Unmapped addresses read zero.
- R12: The clock-setting register keeps bits [4:0], reads them back, and drives them on `clk_cfg_o` bits [5n-1:5n-5] for channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| tick_en | input | 6 | Per-channel count enable from the prescaler |
| irq_o | output | 1 | Level interrupt |
| clk_cfg_o | output | 30 | Clock settings of all channels, 5 bits each |

## Verification
The acknowledge write and a compare hit of the same channel can land on one clock edge. The bench provokes this directly. It first leaves a channel in repeat mode with its status already set and its counter one tick below the compare value. It then drives the tick and the acknowledge of that channel in the same cycle. The judgement is that status still reads 1 afterwards, and that a later acknowledge on its own clears it. A control write with the clear strobe can also meet a tick, and the bench checks that the counter then restarts from zero.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_KEEP    = 2'd2,
    MODE_FREE    = 2'd3
  } mode_e;

  // register select within a channel slot (addr[3:2])
  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_CLK  = 2'd1;
  localparam logic [1:0] RSEL_CNT  = 2'd2;
  localparam logic [1:0] RSEL_CMP  = 2'd3;

  // global slot
  localparam logic [1:0] GSEL_EN   = 2'd0;
  localparam logic [1:0] GSEL_ST   = 2'd1;
  localparam logic [1:0] GSEL_ACK  = 2'd2;

  // extension slot for the wide channel
  localparam logic [1:0] XSEL_CNTHI = 2'd0;
  localparam logic [1:0] XSEL_CMPHI = 2'd1;

  // control bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_CLR = 1;
  localparam int CTL_MLO = 4;
  localparam int CTL_MHI = 5;
endpackage

// File: rtl/mtmr_channel.sv
module mtmr_channel
  import mtmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic          cmp_lo_we,
  input  logic          cmp_hi_we,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic          run,
  output mode_e         mode,
  output logic          hit
);
  logic [CW-1:0] nxt;
  logic [DW-1:0] cmp_lo;

  assign nxt = cnt + CW'(1);
  assign hit = run && tick && !ctrl_we && (mode != MODE_FREE) && (nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      mode <= MODE_ONESHOT;
    end else if (ctrl_we) begin
      run  <= wdata[CTL_EN];
      mode <= mode_e'(wdata[CTL_MHI:CTL_MLO]);
      if (wdata[CTL_CLR]) cnt <= '0;
    end else if (run && tick) begin
      if (hit && mode == MODE_REPEAT) cnt <= '0;
      else                            cnt <= nxt;
      if (hit && mode == MODE_ONESHOT) run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cmp_lo <= '0;
    else if (cmp_lo_we) cmp_lo <= wdata;
  end

  generate
    if (CW > DW) begin : g_wide
      logic [CW-DW-1:0] cmp_hi;
      always_ff @(posedge clk) begin
        if (rst)            cmp_hi <= '0;
        else if (cmp_hi_we) cmp_hi <= wdata[CW-DW-1:0];
      end
      assign cmp = {cmp_hi, cmp_lo};
    end else begin : g_narrow
      logic unused_hi_we;
      assign unused_hi_we = cmp_hi_we;
      assign cmp = cmp_lo;
    end
  endgenerate
endmodule

// File: rtl/mtmr_irq.sv
module mtmr_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              ack_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] enable,
  output logic [NUM_CH-1:0] status,
  output logic              irq
);
  logic [NUM_CH-1:0] clr_mask;

  assign clr_mask = ack_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_we) enable <= wbits;
      status <= (status & ~clr_mask) | hit;
      irq    <= |(status & enable);
    end
  end
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import mtmr_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int WIDE_CH   = 6,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int CLK_CFG_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [AW-1:0]               addr,
  input  logic                        wr_en,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rd_data,
  input  logic [NUM_CH-1:0]           tick_en,
  output logic                        irq_o,
  output logic [NUM_CH*CLK_CFG_W-1:0] clk_cfg_o
);
  localparam int WW       = 2 * DW;
  localparam int SW       = AW - 4;
  localparam int EXT_SLOT = NUM_CH + 1;

  logic [SW-1:0] slot;
  logic [1:0]    rsel;
  assign slot = addr[AW-1:4];
  assign rsel = addr[3:2];

  logic [NUM_CH-1:0][DW-1:0]        ch_cnt_lo, ch_cmp_lo, ch_ctl;
  logic [NUM_CH-1:0][CLK_CFG_W-1:0] clk_cfg;
  logic [NUM_CH-1:0]                hit_vec, irq_en, irq_st;
  logic [DW-1:0]                    wide_cnt_hi, wide_cmp_hi, hi_latch, rd_next;
  logic                             ext_cmphi_we;

  assign ext_cmphi_we = wr_en && (slot == SW'(EXT_SLOT)) && (rsel == XSEL_CMPHI);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int CW = (g + 1 == WIDE_CH) ? WW : DW;
      logic          sel;
      logic [CW-1:0] cnt_w, cmp_w;
      logic          run;
      mode_e         mode;
      logic [CLK_CFG_W-1:0] cfg_q;

      assign sel = wr_en && (slot == SW'(g + 1));

      mtmr_channel #(.DW(DW), .CW(CW)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en[g]),
        .ctrl_we   (sel && rsel == RSEL_CTRL),
        .cmp_lo_we (sel && rsel == RSEL_CMP),
        .cmp_hi_we (ext_cmphi_we),
        .wdata     (wdata),
        .cnt       (cnt_w),
        .cmp       (cmp_w),
        .run       (run),
        .mode      (mode),
        .hit       (hit_vec[g])
      );

      always_ff @(posedge clk) begin
        if (rst)                         cfg_q <= '0;
        else if (sel && rsel == RSEL_CLK) cfg_q <= wdata[CLK_CFG_W-1:0];
      end

      assign clk_cfg[g]   = cfg_q;
      assign ch_cnt_lo[g] = cnt_w[DW-1:0];
      assign ch_cmp_lo[g] = cmp_w[DW-1:0];
      assign ch_ctl[g]    = DW'({mode, 3'b000, run});

      if (CW > DW) begin : g_hi
        assign wide_cnt_hi = cnt_w[CW-1:DW];
        assign wide_cmp_hi = cmp_w[CW-1:DW];
      end
    end
  endgenerate

  mtmr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .en_we  (wr_en && slot == '0 && rsel == GSEL_EN),
    .ack_we (wr_en && slot == '0 && rsel == GSEL_ACK),
    .wbits  (wdata[NUM_CH-1:0]),
    .hit    (hit_vec),
    .enable (irq_en),
    .status (irq_st),
    .irq    (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (slot == '0) begin
      case (rsel)
        GSEL_EN: rd_next = DW'(irq_en);
        GSEL_ST: rd_next = DW'(irq_st);
        default: rd_next = '0;
      endcase
    end else if (slot == SW'(EXT_SLOT)) begin
      case (rsel)
        XSEL_CNTHI: rd_next = hi_latch;
        XSEL_CMPHI: rd_next = wide_cmp_hi;
        default:    rd_next = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (slot == SW'(i + 1)) begin
          case (rsel)
            RSEL_CTRL: rd_next = ch_ctl[i];
            RSEL_CLK:  rd_next = DW'(clk_cfg[i]);
            RSEL_CNT:  rd_next = ch_cnt_lo[i];
            default:   rd_next = ch_cmp_lo[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      hi_latch <= '0;
    end else begin
      rd_data <= rd_next;
      if (!wr_en && slot == SW'(WIDE_CH) && rsel == RSEL_CNT)
        hi_latch <= wide_cnt_hi;
    end
  end

  assign clk_cfg_o = clk_cfg;
endmodule

// File: rtl/multi_timer_chk.sv
module multi_timer_chk #(
  parameter int NUM_CH = 6,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [AW-1:0]             addr,
  input logic                      wr_en,
  input logic [NUM_CH-1:0]         ack_bits,
  input logic [DW-1:0]             rd_data,
  input logic [NUM_CH-1:0]         tick_en,
  input logic                      irq_o,
  input logic [NUM_CH-1:0]         hit_vec,
  input logic [NUM_CH-1:0]         irq_st,
  input logic [NUM_CH-1:0]         irq_en,
  input logic [NUM_CH-1:0][DW-1:0] ch_cnt_lo
);
  localparam logic [AW-1:0] ACK_ADDR = AW'(8);

  // R9: acknowledge address reads as zero
  p_ack_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ACK_ADDR) |-> (rd_data == '0));

  // R8: interrupt follows masked status one cycle later
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    ((irq_st & irq_en) == '0) |=> !irq_o);
  p_irq_raised_r8: assert property (@(posedge clk) disable iff (rst)
    ((irq_st & irq_en) != '0) |=> irq_o);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      localparam logic [AW-1:0] CTRL_ADDR = AW'((i + 1) * 16);
      // R2: no tick and no control write means the counter holds
      p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en[i] && !(wr_en && addr == CTRL_ADDR)) |=> $stable(ch_cnt_lo[i]));
      // R3: a compare hit raises status
      p_hit_sets_status_r3: assert property (@(posedge clk) disable iff (rst)
        hit_vec[i] |=> irq_st[i]);
      // R9: acknowledge without a competing hit clears status
      p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ACK_ADDR && ack_bits[i] && !hit_vec[i]) |=> !irq_st[i]);
    end
  endgenerate
endmodule

bind multi_timer multi_timer_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_en     (wr_en),
  .ack_bits  (wdata[NUM_CH-1:0]),
  .rd_data   (rd_data),
  .tick_en   (tick_en),
  .irq_o     (irq_o),
  .hit_vec   (hit_vec),
  .irq_st    (irq_st),
  .irq_en    (irq_en),
  .ch_cnt_lo (ch_cnt_lo)
);

// File: tb/multi_timer_test.sv
module multi_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [5:0]  tick_en = '0;
  logic        irq_o;
  logic [29:0] clk_cfg_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  multi_timer uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .tick_en(tick_en), .irq_o(irq_o), .clk_cfg_o(clk_cfg_o)
  );

  function automatic logic [7:0] a_ctrl(input int n); return 8'(n * 16); endfunction
  function automatic logic [7:0] a_clk (input int n); return 8'(n * 16 + 4); endfunction
  function automatic logic [7:0] a_cnt (input int n); return 8'(n * 16 + 8); endfunction
  function automatic logic [7:0] a_cmp (input int n); return 8'(n * 16 + 12); endfunction
  localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_ACK = 8'h08;
  localparam logic [7:0] A_CNTHI = 8'h70, A_CMPHI = 8'h74;

  // expected counter after n ticks with compare c (mode 0 oneshot, 1 repeat, 2 keep, 3 free)
  function automatic int exp_cnt(input int mode, input int c, input int n);
    case (mode)
      0: return (n < c) ? n : c;
      1: return n % c;
      default: return n;
    endcase
  endfunction
  function automatic int exp_st(input int mode, input int c, input int n);
    return (mode != 3 && n >= c) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic tick(input logic [5:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = m;
      @(posedge clk);
    end
    @(negedge clk);
    tick_en = '0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_ST, v);      chk("R1 status", v, 0);
    rd(a_ctrl(1), v); chk("R1 ctrl1", v, 0);
    rd(a_cnt(6), v);  chk("R1 cnt6", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 clk_cfg", clk_cfg_o, 0);

    // R7 / R3 repeat on channel 1
    wr(a_cmp(1), 4);
    wr(a_ctrl(1), 32'h13);
    rd(a_ctrl(1), v); chk("R7 clear bit reads 0", v, 32'h11);
    tick(6'h01, 3);
    rd(a_cnt(1), v);  chk("R2 cnt after 3", v, 3);
    rd(A_ST, v);      chk("R3 no status yet", v[0], 0);
    tick(6'h01, 1);
    rd(a_cnt(1), v);  chk("R3 reload to 0", v, 0);
    rd(A_ST, v);      chk("R3 status set", v[0], 1);
    tick(6'h01, 2);
    rd(a_cnt(1), v);  chk("R3 keeps running", v, 2);

    // R8 interrupt masking
    chk("R8 masked", irq_o, 0);
    wr(A_EN, 32'h1);
    rd(A_EN, v);      chk("R8 irq raised", irq_o, 1);
    wr(A_EN, 32'h0);
    rd(A_EN, v);      chk("R8 irq masked again", irq_o, 0);

    // R9 hit and acknowledge in the same cycle
    tick(6'h01, 1);
    @(negedge clk);
    tick_en = 6'h01; addr = A_ACK; wdata = 32'h1; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = '0; wr_en = 1'b0;
    rd(A_ST, v);      chk("R9 hit wins over ack", v[0], 1);
    rd(a_cnt(1), v);  chk("R3 reload on coincident hit", v, 0);
    wr(A_ACK, 32'h1);
    rd(A_ST, v);      chk("R9 ack clears", v[0], 0);
    rd(A_ACK, v);     chk("R9 ack reads 0", v, 0);

    // R7 clear while running, together with a tick
    tick(6'h01, 2);
    @(negedge clk);
    tick_en = 6'h01; addr = a_ctrl(1); wdata = 32'h13; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = '0; wr_en = 1'b0;
    rd(a_cnt(1), v);  chk("R7 clear restarts at 0", v, 0);

    // R2 disabled channel and foreign ticks
    wr(a_ctrl(1), 32'h02);
    tick(6'h01, 5);
    rd(a_cnt(1), v);  chk("R2 disabled holds", v, 0);
    wr(a_cmp(2), 100);
    wr(a_ctrl(2), 32'h23);
    tick(6'h01, 5);
    rd(a_cnt(2), v);  chk("R2 other tick ignored", v, 0);
    tick(6'h02, 3);
    rd(a_cnt(2), v);  chk("R2 own ticks", v, 3);
    wr(a_ctrl(2), 32'h02);

    // R4 oneshot
    wr(a_cmp(3), 3);
    wr(a_ctrl(3), 32'h03);
    tick(6'h04, 5);
    rd(a_cnt(3), v);  chk("R4 stops at compare", v, 3);
    rd(a_ctrl(3), v); chk("R4 enable cleared", v, 0);
    rd(A_ST, v);      chk("R4 status", v[2], 1);

    // R5 keep-going
    wr(a_cmp(4), 2);
    wr(a_ctrl(4), 32'h23);
    tick(6'h08, 5);
    rd(a_cnt(4), v);  chk("R5 continues", v, 5);
    rd(A_ST, v);      chk("R5 status", v[3], 1);

    // R6 free-run
    wr(a_cmp(5), 3);
    wr(a_ctrl(5), 32'h33);
    tick(6'h10, 5);
    rd(a_cnt(5), v);  chk("R6 counts", v, 5);
    rd(A_ST, v);      chk("R6 no status", v[4], 0);
    wr(a_ctrl(5), 32'h02);
    wr(a_ctrl(4), 32'h02);

    // R10 wide channel
    wr(a_cmp(6), 5);
    wr(A_CMPHI, 1);
    rd(A_CMPHI, v);   chk("R10 cmp hi readback", v, 1);
    wr(a_ctrl(6), 32'h23);
    tick(6'h20, 10);
    rd(a_cnt(6), v);  chk("R10 cnt low", v, 10);
    rd(A_CNTHI, v);   chk("R10 latched hi", v, 0);
    rd(A_ST, v);      chk("R10 upper word blocks hit", v[5], 0);
    wr(A_CMPHI, 0);
    wr(a_ctrl(6), 32'h23 | 32'h2);
    tick(6'h20, 5);
    rd(A_ST, v);      chk("R10 full match", v[5], 1);
    wr(a_ctrl(6), 32'h02);

    // R11 unmapped, R12 clock setting
    rd(8'h0C, v);     chk("R11 unmapped 0x0C", v, 0);
    rd(8'h78, v);     chk("R11 unmapped 0x78", v, 0);
    wr(a_clk(2), 32'hFF);
    rd(a_clk(2), v);  chk("R12 clk readback", v, 32'h1F);
    chk("R12 clk_cfg_o ch2", clk_cfg_o[9:5], 5'h1F);
    chk("R12 clk_cfg_o others", {clk_cfg_o[29:10], clk_cfg_o[4:0]}, 0);

    // random phase
    for (int it = 0; it < 24; it++) begin
      int ch, mode, c, n, got_n;
      logic [5:0] msk, own;
      ch   = 1 + int'($urandom % 5);
      mode = int'($urandom % 4);
      c    = 2 + int'($urandom % 15);
      n    = int'($urandom % 40);
      msk  = 6'($urandom);
      own  = 6'(1 << (ch - 1));
      wr(A_ACK, 32'h3F);
      wr(A_EN, {26'b0, msk});
      wr(a_cmp(ch), c);
      wr(a_ctrl(ch), (mode << 4) | 3);
      got_n = 0;
      while (got_n < n) begin
        @(negedge clk);
        if ($urandom % 3 == 0) tick_en = 6'($urandom) & ~own;
        else begin tick_en = own | (6'($urandom) & ~own); got_n++; end
        @(posedge clk);
      end
      @(negedge clk);
      tick_en = '0;
      rd(a_cnt(ch), v); chk("R2 random cnt", v, exp_cnt(mode, c, n));
      rd(A_ST, v);      chk("R3 random status", v, 32'(exp_st(mode, c, n)) << (ch - 1));
      rd(a_ctrl(ch), v);
      chk("R4 random ctrl", v, (mode << 4) | ((mode == 0 && n >= c) ? 0 : 1));
      chk("R8 random irq", irq_o, exp_st(mode, c, n) != 0 && msk[ch-1]);
      wr(a_ctrl(ch), 32'h02);
    end

    summary();
  end
endmodule